// File: doc/BRIEF.md
# Endian-Selectable Width Downsizer

The block takes 32-bit long words from an upstream queue and sends each one out as a short series of narrow items. An item is either an 8-bit byte (four beats per long word) or a 16-bit half word (two beats per long word). The block takes its byte order and its item size from two plain configuration pins. It captures both pins when reset is released and keeps them until the next reset. In big-endian order the most significant item leaves first. In little-endian order the least significant item leaves first.

Both data sides use valid/ready. An input word transfers on a clock edge where `in_valid` and `in_ready` are both high. An output item transfers on an edge where `out_valid` and `out_ready` are both high. Downstream may hold `out_ready` low for as long as it needs, and the presented item then stays frozen. Upstream sees `in_ready` low until the final item of the held word is being taken. On that cycle a new word may load straight in, so a stream of words flows without idle cycles.

Top module: `dsz_downsizer`

## Requirements
- R1: `order_sel` and `size_sel` are captured on the last rising clock edge at which `rst_n` is low. Any change to them while `rst_n` is high has no effect until the next reset.
- R2: With `order_sel`=1 (big-endian) the most significant item of the word leaves first. In byte mode the beats are bits [31:24], [23:16], [15:8], [7:0]. In half mode the beats are [31:16], [15:0].
- R3: With `order_sel`=0 (little-endian) the least significant item leaves first. In byte mode the beats are bits [7:0], [15:8], [23:16], [31:24]. In half mode the beats are [15:0], [31:16].
- R4: With `size_sel`=0 each word gives four byte beats, with the byte on `out_data[7:0]` and `out_data[15:8]`=0. With `size_sel`=1 each word gives two 16-bit beats on `out_data[15:0]`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_last` stay unchanged on the next cycle.
- R6: While a word is held, `in_ready` is low, except in a cycle where the word's final beat is presented with `out_ready` high. A word accepted on an edge presents its first beat with `out_valid` high from the next cycle.
- R7: While `rst_n` is low, `out_valid` is low. After release, with no word held, `in_ready` is high.
- R8: `out_last` is high exactly on the final beat of each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| order_sel | input | 1 | Byte order pin: 1 = big-endian, 0 = little-endian |
| size_sel | input | 1 | Item size pin: 0 = byte, 1 = 16-bit half word |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 32 | Upstream long word |
| in_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | Narrow item valid |
| out_data | output | 16 | Narrow item; upper byte zero in byte mode |
| out_last | output | 1 | Item is the last of its word |
| out_ready | input | 1 | Downstream takes the item this cycle |

## Verification
There is one register stage between a word handshake and its first beat. The first beat therefore appears on the cycle after the accepting edge, and each later beat appears one cycle after the edge that consumed the previous beat. `in_ready` is combinational from `out_ready` and the beat state, so it is valid in the same cycle. The bench drives inputs just after the falling edge and samples outputs a moment later, before the next rising edge. Every check therefore sees the state left by the last edge together with the current inputs. Configuration checks load a word after reset and read the beat order from the outputs. This shows which pin values were captured, including after the pins are toggled once reset is released.

// File: rtl/dsz_pkg.sv
package dsz_pkg;
  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } order_e;

  typedef enum logic {
    SIZE_BYTE = 1'b0,
    SIZE_HALF = 1'b1
  } size_e;

  typedef struct packed {
    order_e order;
    size_e  size;
  } dsz_cfg_t;
endpackage

// File: rtl/dsz_cfg_latch.sv
module dsz_cfg_latch
  import dsz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      order_pin,
  input  logic      size_pin,
  output dsz_cfg_t  cfg
);
  // Follows the pins during reset, freezes once reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.order <= order_e'(order_pin);
      cfg.size  <= size_e'(size_pin);
    end
  end

  assert_cfg_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg));
endmodule

// File: rtl/dsz_slice_sel.sv
module dsz_slice_sel
  import dsz_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int BYTE_BEATS = WORD_W / BYTE_W,
  localparam int HALF_BEATS = WORD_W / HALF_W,
  localparam int CNT_W  = (BYTE_BEATS > 1) ? $clog2(BYTE_BEATS) : 1,
  localparam int HCNT_W = (HALF_BEATS > 1) ? $clog2(HALF_BEATS) : 1
)(
  input  dsz_cfg_t          cfg,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  beat,
  output logic [HALF_W-1:0] data
);
  logic [BYTE_W-1:0] bytes [BYTE_BEATS];
  logic [HALF_W-1:0] halves[HALF_BEATS];

  for (genvar b = 0; b < BYTE_BEATS; b++) begin : g_byte
    assign bytes[b] = word[b*BYTE_W +: BYTE_W];
  end
  for (genvar h = 0; h < HALF_BEATS; h++) begin : g_half
    assign halves[h] = word[h*HALF_W +: HALF_W];
  end

  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  idx;
  logic [HCNT_W-1:0] hidx;

  always_comb begin
    last_idx = (cfg.size == SIZE_HALF) ? CNT_W'(HALF_BEATS - 1) : CNT_W'(BYTE_BEATS - 1);
    idx      = (cfg.order == ORDER_BIG) ? (last_idx - beat) : beat;
    hidx     = idx[HCNT_W-1:0];
    if (cfg.size == SIZE_HALF) data = halves[hidx];
    else                       data = {{(HALF_W-BYTE_W){1'b0}}, bytes[idx]};
  end
endmodule

// File: rtl/dsz_sequencer.sv
module dsz_sequencer
  import dsz_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int BYTE_BEATS = WORD_W / BYTE_W,
  localparam int HALF_BEATS = WORD_W / HALF_W,
  localparam int CNT_W = (BYTE_BEATS > 1) ? $clog2(BYTE_BEATS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  dsz_cfg_t          cfg,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic [WORD_W-1:0] word_q,
  output logic [CNT_W-1:0]  beat_q
);
  logic             full_q;
  logic [CNT_W-1:0] last_idx;
  logic             in_fire, out_fire;

  always_comb begin
    last_idx  = (cfg.size == SIZE_HALF) ? CNT_W'(HALF_BEATS - 1) : CNT_W'(BYTE_BEATS - 1);
    out_valid = full_q;
    out_last  = full_q && (beat_q == last_idx);
    out_fire  = full_q && out_ready;
    in_ready  = !full_q || (out_ready && out_last);
    in_fire   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      beat_q <= '0;
      word_q <= '0;
    end else if (in_fire) begin
      word_q <= in_data;
      full_q <= 1'b1;
      beat_q <= '0;
    end else if (out_fire) begin
      if (out_last) begin
        full_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && beat_q == '0));
  assert_beat_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q <= last_idx);
  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !in_valid) |=> !out_valid);
endmodule

// File: rtl/dsz_downsizer.sv
module dsz_downsizer
  import dsz_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int BYTE_BEATS = WORD_W / BYTE_W,
  localparam int CNT_W = (BYTE_BEATS > 1) ? $clog2(BYTE_BEATS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic              size_sel,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);
  dsz_cfg_t          cfg;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  beat_q;

  dsz_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .order_pin(order_sel), .size_pin(size_sel), .cfg(cfg)
  );

  dsz_sequencer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .word_q(word_q), .beat_q(beat_q)
  );

  dsz_slice_sel #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_sel (
    .cfg(cfg), .word(word_q), .beat(beat_q), .data(out_data)
  );

  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last)));
  assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg.size == SIZE_BYTE) |-> out_data[HALF_W-1:BYTE_W] == '0);
  assert_reset_idle_R7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/test_dsz_downsizer.sv
module test_dsz_downsizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        order_sel = 1'b0, size_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [15:0] out_data;
  logic        out_ready = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsz_downsizer i_dsz_downsizer (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .size_sel(size_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );

  // {order, size, word}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h11223344},
    {1'b0, 1'b0, 32'h11223344},
    {1'b1, 1'b1, 32'hA1B2C3D4},
    {1'b0, 1'b1, 32'hA1B2C3D4},
    {1'b1, 1'b0, 32'hDEADBEEF},
    {1'b0, 1'b1, 32'h0000FFFF}
  };

  function automatic logic [15:0] exp_beat(logic [31:0] w, logic big, logic half, int k);
    int n = half ? 2 : 4;
    int idx = big ? (n - 1 - k) : k;
    return half ? w[idx*16 +: 16] : {8'h00, w[idx*8 +: 8]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic ord, logic sz);
    @(negedge clk);
    rst_n = 1'b0; order_sel = ord; size_sel = sz;
    in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R7 valid low in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic send_word(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; #1;
    check("R7/R6 in_ready idle", {31'b0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Called right after a negedge where the first beat is visible.
  task automatic drain(string req, logic [31:0] w, logic big, logic half);
    int n = half ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      out_ready = 1'b1; #1;
      check(req, {31'b0, out_valid}, 32'd1);
      check(req, {16'b0, out_data}, {16'b0, exp_beat(w, big, half, k)});
      check("R8 last flag", {31'b0, out_last}, {31'b0, (k == n - 1)});
      if (k < n - 1) check("R6 ready low mid-word", {31'b0, in_ready}, 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b0; #1;
    check("R8 idle after last", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    // Vector table: R2 big, R3 little, R4 sizes
    for (int v = 0; v < NV; v++) begin
      logic ord = VEC[v][33];
      logic sz = VEC[v][32];
      logic [31:0] w = VEC[v][31:0];
      do_reset(ord, sz);
      send_word(w);
      drain(ord ? "R2 big order" : "R3 little order", w, ord, sz);
    end

    // R1: pins toggled after release are ignored
    do_reset(1'b1, 1'b0);
    @(negedge clk); order_sel = 1'b0; size_sel = 1'b1;
    send_word(32'hCAFE0123);
    drain("R1 cfg held", 32'hCAFE0123, 1'b1, 1'b0);
    // R1: next reset picks up new pins
    do_reset(1'b0, 1'b1);
    send_word(32'h89ABCDEF);
    drain("R1 cfg recaptured", 32'h89ABCDEF, 1'b0, 1'b1);

    // R5: back-pressure freezes the output
    do_reset(1'b1, 1'b0);
    send_word(32'h55667788);
    out_ready = 1'b1; #1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    for (int s = 0; s < 3; s++) begin
      #1;
      check("R5 valid held", {31'b0, out_valid}, 32'd1);
      check("R5 data held", {16'b0, out_data}, 32'h66);
      check("R5 last held", {31'b0, out_last}, 32'd0);
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b1; #1;
    check("R5 resume", {16'b0, out_data}, 32'h66);
    @(posedge clk); @(negedge clk);
    check("R5 next", {16'b0, out_data}, 32'h77);
    @(posedge clk); @(negedge clk);
    // R6: last beat with a new word waiting loads it in the same cycle
    in_valid = 1'b1; in_data = 32'h0A0B0C0D; #1;
    check("R6 last beat", {16'b0, out_data}, 32'h88);
    check("R6 pass-through ready", {31'b0, in_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    drain("R6 back-to-back", 32'h0A0B0C0D, 1'b1, 1'b0);

    // R6: last beat stalled keeps in_ready low
    send_word(32'h01020304);
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin @(posedge clk); @(negedge clk); end
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'hFFFFFFFF; #1;
    check("R6 stalled last", {31'b0, out_last}, 32'd1);
    check("R6 ready low stalled", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule